// File: doc/BRIEF.md
# SPI command front end for a CAN controller

This block is the serial side of a stand-alone CAN controller. An external host drives it as an SPI slave in mode 0: eight-bit bytes, most significant bit first, chip select active low. The block decodes the controller's command set and turns it into accesses to a 128-byte internal register space. A separate host-side input lets the surrounding logic (in this project, the testbench) raise the receive-full flags that the receive path would normally set.

Besides plain read and write with an auto-incrementing pointer, the command set has short forms. Some opcodes carry argument bits that preset the pointer to the start of a transmit or receive buffer. One opcode carries per-buffer bits that fire transmit request strobes. Reading a receive buffer through its short form clears that buffer's receive-full flag when chip select goes high. The SPI pins are oversampled by the system clock, so the serial clock must be several times slower than `clk`.

Top module: `can_spi_cmd_if`

## Requirements
- R1: After hardware reset, and after the one-byte command 0xC0, every register reads 0x00 except the control register at 0x0F, which reads 0x80 (mode field bits 7:5 = 100, configuration mode). `int_n` is then high.
- R2: Command 0x02, address, data bytes writes the data bytes to consecutive addresses starting at the address. The pointer wraps from 0x7F to 0x00, and address bit 7 is ignored.
- R3: Command 0x03, address, then dummy bytes returns register contents on `spi_miso`, starting at the address and incrementing after each byte, MSB first. Each bit is valid when `spi_sclk` rises.
- R4: Command 0x05, address, mask, data changes only the bits set in the mask to the matching data bits. Bytes after the data byte are ignored.
- R5: Command 0x40 | s, with s = 0 to 5, sets the write pointer to 0x31 + 0x10*(s>>1) + 5*(s&1), that is 0x31, 0x36, 0x41, 0x46, 0x51 or 0x56. Following bytes are written there as in R2. For s = 6 or 7 the command is ignored and nothing is written.
- R6: Command 0x80 | b, with b in 0 to 7, raises `tx_req[i]` for exactly one `clk` cycle for each set bit i of b.
- R7: Command 0x90 | (s<<1), with s = 0 to 3, returns data as in R3 from start address 0x61, 0x66, 0x71 or 0x76. When chip select rises, it clears bit (s>>1) of the interrupt-flag register at 0x2C.
- R8: Raising chip select aborts a partial command: a write that has no data byte, or a bit-modify that has no data byte, changes no register. The next byte after chip select falls again is decoded as an opcode.
- R9: A byte in opcode position that is none of the commands above makes the rest of the transaction, up to chip select rising, have no effect.
- R10: A pulse on `host_rx_set[i]` sets bit i of register 0x2C. `int_n` is low exactly when register 0x2B (enable) ANDed with 0x2C is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| host_rx_set | input | 2 | One-cycle pulses that set the receive-full flags |
| tx_req | output | 3 | One-cycle transmit request strobes, one per transmit buffer |
| int_n | output | 1 | Active-low interrupt, low while an enabled flag is set |

## Verification
The bench writes across the 0x7F to 0x00 boundary and uses an address with bit 7 set. A pointer that saturates or keeps bit 7 would read back the wrong bytes. It sends bit-modify with partial masks and a trailing extra byte, and it aborts write and bit-modify commands early. A design that merged badly, wrote on a trailing byte, or committed a half-finished command would corrupt a known register. Every buffer selector of both short forms is exercised, including the two illegal transmit selectors, whose mis-decode would land on the receive buffer start addresses that the bench reads back. It also checks that each receive read clears only its own flag, that the interrupt follows the enable mask, and that each request-to-send bit gives exactly one strobe cycle.

// File: rtl/can_spi_pkg.sv
package can_spi_pkg;
    localparam int ADDR_W  = 7;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int TX_BUFS = 3;
    localparam int RX_BUFS = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
    localparam logic [ADDR_W-1:0] IEN_ADDR  = 7'h2B;
    localparam logic [ADDR_W-1:0] IFLG_ADDR = 7'h2C;
    localparam logic [7:0]        CFG_MODE  = 8'h80;

    localparam logic [ADDR_W-1:0] TX_BASE = 7'h31;
    localparam logic [ADDR_W-1:0] RX_BASE = 7'h61;
    localparam logic [ADDR_W-1:0] HDR_GAP = 7'd5;

    localparam logic [7:0] OP_RESET = 8'hC0;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_BMOD  = 8'h05;

    typedef enum logic [3:0] {
        ST_OPC, ST_RD_ADDR, ST_RD_DATA, ST_WR_ADDR, ST_WR_DATA,
        ST_BM_ADDR, ST_BM_MASK, ST_BM_DATA, ST_IGN
    } cmd_state_e;
endpackage

// File: rtl/can_spi_shift.sv
module can_spi_shift #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    output logic       miso,
    output logic       cs_hi,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] s_sclk;
        logic [SYNC_STAGES-1:0] s_cs;
        logic [SYNC_STAGES-1:0] s_mosi;
        logic                   sclk_prev;
        logic [2:0]             cnt;
        logic [6:0]             rx_sh;
        logic [7:0]             rx_byte;
        logic                   rx_valid;
        logic [7:0]             tx_sh;
    } shift_t;

    shift_t q, d;
    logic sclk_s, mosi_s, rise, fall;

    always_comb begin
        sclk_s = q.s_sclk[SYNC_STAGES-1];
        mosi_s = q.s_mosi[SYNC_STAGES-1];
        rise   = sclk_s & ~q.sclk_prev;
        fall   = ~sclk_s & q.sclk_prev;

        d           = q;
        d.s_sclk    = {q.s_sclk[SYNC_STAGES-2:0], sclk};
        d.s_cs      = {q.s_cs[SYNC_STAGES-2:0], cs_n};
        d.s_mosi    = {q.s_mosi[SYNC_STAGES-2:0], mosi};
        d.sclk_prev = sclk_s;
        d.rx_valid  = 1'b0;

        if (q.s_cs[SYNC_STAGES-1]) begin
            d.cnt   = 3'd0;
            d.tx_sh = 8'h00;
        end else begin
            if (rise) begin
                d.rx_sh = {q.rx_sh[5:0], mosi_s};
                d.cnt   = q.cnt + 3'd1;
                if (q.cnt == 3'd7) begin
                    d.rx_byte  = {q.rx_sh, mosi_s};
                    d.rx_valid = 1'b1;
                end
            end
            // the falling edge that closes a byte must keep the freshly loaded MSB
            if (fall && q.cnt != 3'd0) begin
                d.tx_sh = {q.tx_sh[6:0], 1'b0};
            end
            if (tx_load) begin
                d.tx_sh = tx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s_sclk: '0, s_cs: '1, s_mosi: '0, sclk_prev: 1'b0, cnt: 3'd0,
                   rx_sh: 7'd0, rx_byte: 8'h00, rx_valid: 1'b0, tx_sh: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign miso     = q.tx_sh[7];
    assign cs_hi    = q.s_cs[SYNC_STAGES-1];
    assign rx_valid = q.rx_valid;
    assign rx_byte  = q.rx_byte;
endmodule

// File: rtl/can_spi_decode.sv
module can_spi_decode
    import can_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_hi,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic [7:0]         rd_data,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [7:0]         wr_data,
    output logic [7:0]         wr_mask,
    output logic               soft_rst,
    output logic               clr_en,
    output logic               clr_bit,
    output logic               tx_load,
    output logic [7:0]         tx_data,
    output logic [TX_BUFS-1:0] tx_req
);
    typedef struct packed {
        cmd_state_e          state;
        logic [ADDR_W-1:0]   ptr;
        logic [7:0]          mask;
        logic                rx_pend;
        logic                rx_sel;
        logic                tx_load;
        logic [7:0]          tx_data;
        logic [TX_BUFS-1:0]  tx_req;
    } dec_t;

    dec_t q, d;
    logic [ADDR_W-1:0] tx_preset, rx_preset;

    always_comb begin
        tx_preset = TX_BASE + {1'b0, rx_byte[2:1], 4'h0} + (rx_byte[0] ? HDR_GAP : 7'd0);
        rx_preset = RX_BASE + {2'b00, rx_byte[2], 4'h0} + (rx_byte[1] ? HDR_GAP : 7'd0);

        d         = q;
        d.tx_load = 1'b0;
        d.tx_req  = '0;
        rd_addr   = q.ptr;
        wr_en     = 1'b0;
        wr_addr   = q.ptr;
        wr_data   = rx_byte;
        wr_mask   = 8'hFF;
        soft_rst  = 1'b0;
        clr_en    = 1'b0;
        clr_bit   = q.rx_sel;

        if (cs_hi) begin
            d.state   = ST_OPC;
            d.rx_pend = 1'b0;
            clr_en    = q.rx_pend;
        end else if (rx_valid) begin
            unique case (q.state)
                ST_OPC: begin
                    casez (rx_byte)
                        OP_RESET: begin soft_rst = 1'b1; d.state = ST_IGN; end
                        OP_READ:  d.state = ST_RD_ADDR;
                        OP_WRITE: d.state = ST_WR_ADDR;
                        OP_BMOD:  d.state = ST_BM_ADDR;
                        8'b0100_0???: begin
                            if (rx_byte[2:0] <= 3'd5) begin
                                d.ptr   = tx_preset;
                                d.state = ST_WR_DATA;
                            end else begin
                                d.state = ST_IGN;
                            end
                        end
                        8'b1000_0???: begin
                            d.tx_req = rx_byte[TX_BUFS-1:0];
                            d.state  = ST_IGN;
                        end
                        8'b1001_0??0: begin
                            rd_addr   = rx_preset;
                            d.tx_load = 1'b1;
                            d.tx_data = rd_data;
                            d.ptr     = rx_preset + 7'd1;
                            d.rx_pend = 1'b1;
                            d.rx_sel  = rx_byte[2];
                            d.state   = ST_RD_DATA;
                        end
                        default: d.state = ST_IGN;
                    endcase
                end
                ST_RD_ADDR: begin
                    rd_addr   = rx_byte[ADDR_W-1:0];
                    d.tx_load = 1'b1;
                    d.tx_data = rd_data;
                    d.ptr     = rx_byte[ADDR_W-1:0] + 7'd1;
                    d.state   = ST_RD_DATA;
                end
                ST_RD_DATA: begin
                    d.tx_load = 1'b1;
                    d.tx_data = rd_data;
                    d.ptr     = q.ptr + 7'd1;
                end
                ST_WR_ADDR: begin
                    d.ptr   = rx_byte[ADDR_W-1:0];
                    d.state = ST_WR_DATA;
                end
                ST_WR_DATA: begin
                    wr_en = 1'b1;
                    d.ptr = q.ptr + 7'd1;
                end
                ST_BM_ADDR: begin
                    d.ptr   = rx_byte[ADDR_W-1:0];
                    d.state = ST_BM_MASK;
                end
                ST_BM_MASK: begin
                    d.mask  = rx_byte;
                    d.state = ST_BM_DATA;
                end
                ST_BM_DATA: begin
                    wr_en   = 1'b1;
                    wr_mask = q.mask;
                    d.state = ST_IGN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_OPC, ptr: '0, mask: 8'h00, rx_pend: 1'b0, rx_sel: 1'b0,
                   tx_load: 1'b0, tx_data: 8'h00, tx_req: '0};
        end else begin
            q <= d;
        end
    end

    assign tx_load = q.tx_load;
    assign tx_data = q.tx_data;
    assign tx_req  = q.tx_req;

    AST_TXREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.tx_req) |=> (q.tx_req == '0));  // R6

    AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_WR_DATA || q.state == ST_RD_DATA) && rx_valid && !cs_hi)
        |=> (q.ptr == $past(q.ptr) + 7'd1));  // R2
endmodule

// File: rtl/can_spi_regs.sv
module can_spi_regs
    import can_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         wr_mask,
    input  logic               soft_rst,
    input  logic               clr_en,
    input  logic               clr_bit,
    input  logic [RX_BUFS-1:0] host_set,
    output logic               int_n
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    logic [2:0] clr_idx;

    assign clr_idx = {2'b00, clr_bit};

    always_comb begin
        mem_d = mem_q;
        if (soft_rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = 8'h00;
            end
            mem_d[CTRL_ADDR] = CFG_MODE;
        end else begin
            if (wr_en) begin
                mem_d[wr_addr] = (mem_q[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
            end
            if (clr_en) begin
                mem_d[IFLG_ADDR][clr_idx] = 1'b0;
            end
        end
        mem_d[IFLG_ADDR][RX_BUFS-1:0] = mem_d[IFLG_ADDR][RX_BUFS-1:0] | host_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= (i == int'(CTRL_ADDR)) ? CFG_MODE : 8'h00;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign int_n   = ~|(mem_q[IEN_ADDR] & mem_q[IFLG_ADDR]);

    AST_SOFT_RESET_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mem_q[CTRL_ADDR] == CFG_MODE));  // R1

    AST_MASKED_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst && wr_addr != IFLG_ADDR)
        |=> ((((mem_q[$past(wr_addr)] ^ $past(mem_q[wr_addr])) & ~$past(wr_mask)) == 8'h00)
             && (((mem_q[$past(wr_addr)] ^ $past(wr_data)) & $past(wr_mask)) == 8'h00)));  // R4

    AST_RX_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !soft_rst && !host_set[clr_bit] && !(wr_en && wr_addr == IFLG_ADDR))
        |=> !mem_q[IFLG_ADDR][{2'b00, $past(clr_bit)}]);  // R7
endmodule

// File: rtl/can_spi_cmd_if.sv
module can_spi_cmd_if
    import can_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    input  logic [RX_BUFS-1:0] host_rx_set,
    output logic [TX_BUFS-1:0] tx_req,
    output logic               int_n
);
    logic              cs_hi, rx_valid, tx_load;
    logic [7:0]        rx_byte, tx_data, rd_data, wr_data, wr_mask;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              wr_en, soft_rst, clr_en, clr_bit;

    can_spi_shift #(.SYNC_STAGES(2)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_load(tx_load), .tx_data(tx_data), .miso(spi_miso), .cs_hi(cs_hi),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    can_spi_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .soft_rst(soft_rst), .clr_en(clr_en),
        .clr_bit(clr_bit), .tx_load(tx_load), .tx_data(tx_data), .tx_req(tx_req)
    );

    can_spi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask), .soft_rst(soft_rst),
        .clr_en(clr_en), .clr_bit(clr_bit), .host_set(host_rx_set), .int_n(int_n)
    );
endmodule

// File: tb/can_spi_cmd_if_tb.sv
module can_spi_cmd_if_tb;
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [1:0] host_set = 2'b00;
    logic [2:0] tx_req;
    logic       int_n;

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct { logic [7:0] v; int r; } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    logic [2:0] tx_seen = 3'b000;
    int         tx_cycles = 0;
    bit         tx_clear = 0;

    always #4 clk = ~clk;

    can_spi_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .host_rx_set(host_set), .tx_req(tx_req), .int_n(int_n)
    );

    // monitor: pops scoreboard pairs as read bytes arrive
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            total++;
            if (a.v !== e.v) begin
                bad++;
                $display("FAIL R%0d read byte: actual %h expected %h", e.r, a.v, e.v);
            end
        end
    end

    always @(negedge clk) begin
        if (tx_clear) begin
            tx_seen   <= 3'b000;
            tx_cycles <= 0;
        end else if (tx_req != 3'b000) begin
            tx_seen   <= tx_seen | tx_req;
            tx_cycles <= tx_cycles + 1;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int r, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            waitc(HALF);
            sclk = 1'b1;
            i[b] = miso;
            waitc(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        waitc(HALF);
    endtask

    task automatic desel();
        waitc(HALF);
        cs_n = 1'b1;
        waitc(2 * HALF);
    endtask

    task automatic send(input logic [7:0] o);
        logic [7:0] dummy;
        xfer(o, dummy);
    endtask

    task automatic expect_byte(input logic [7:0] e, input int r);
        logic [7:0] got;
        item_t it;
        xfer(8'h00, got);
        it.v = e; it.r = r; exp_q.push_back(it);
        it.v = got; act_q.push_back(it);
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] d);
        sel(); send(8'h02); send(a); send(d); desel();
    endtask

    task automatic rd1(input logic [7:0] a, input logic [7:0] e, input int r);
        sel(); send(8'h03); send(a); expect_byte(e, r); desel();
    endtask

    task automatic host_pulse(input logic [1:0] s);
        host_set = s;
        waitc(1);
        host_set = 2'b00;
        waitc(3);
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);

        // R1 reset state
        chk({7'd0, int_n}, 8'h01, 1, "int_n after reset");
        chk({5'd0, tx_req}, 8'h00, 1, "tx_req after reset");
        rd1(8'h0F, 8'h80, 1);
        rd1(8'h2C, 8'h00, 1);

        // R2 burst write, R3 burst read
        sel(); send(8'h02); send(8'h20); send(8'hAA); send(8'h55); send(8'hC3); desel();
        sel(); send(8'h03); send(8'h20);
        expect_byte(8'hAA, 3); expect_byte(8'h55, 3); expect_byte(8'hC3, 3); desel();

        // R2 wrap from 0x7F to 0x00, and address bit 7 ignored
        sel(); send(8'h02); send(8'h7F); send(8'h11); send(8'h22); desel();
        sel(); send(8'h03); send(8'h7F); expect_byte(8'h11, 2); expect_byte(8'h22, 2); desel();
        wr1(8'h85, 8'h5A);
        rd1(8'h05, 8'h5A, 2);

        // R4 bit-modify, trailing byte ignored
        sel(); send(8'h05); send(8'h20); send(8'h0F); send(8'h35); desel();
        rd1(8'h20, 8'hA5, 4);
        sel(); send(8'h05); send(8'h21); send(8'hF0); send(8'h00); send(8'hFF); send(8'hFF); desel();
        rd1(8'h21, 8'h05, 4);

        // R8 aborted write and aborted bit-modify
        sel(); send(8'h02); send(8'h40); desel();
        rd1(8'h40, 8'h00, 8);
        sel(); send(8'h05); send(8'h20); send(8'hFF); desel();
        rd1(8'h20, 8'hA5, 8);

        // R9 unknown opcode swallows the rest of the transaction
        sel(); send(8'hFF); send(8'h02); send(8'h30); send(8'h99); desel();
        rd1(8'h30, 8'h00, 9);

        // R5 load-transmit selectors 0..5, then illegal 6 and 7
        for (int s = 0; s < 6; s++) begin
            sel(); send(8'h40 | 8'(s)); send(8'hE0 + 8'(s)); send(8'hF0 + 8'(s)); desel();
        end
        for (int s = 0; s < 6; s++) begin
            logic [7:0] a;
            a = 8'h31 + 8'h10 * 8'(s / 2) + ((s % 2) ? 8'd5 : 8'd0);
            sel(); send(8'h03); send(a);
            expect_byte(8'hE0 + 8'(s), 5); expect_byte(8'hF0 + 8'(s), 5); desel();
        end
        sel(); send(8'h46); send(8'h77); desel();
        sel(); send(8'h47); send(8'h78); desel();
        rd1(8'h61, 8'h00, 5);
        rd1(8'h66, 8'h00, 5);

        // R6 request-to-send strobes
        tx_clear = 1; waitc(2); tx_clear = 0;
        sel(); send(8'h85); desel();
        chk({5'd0, tx_seen}, 8'h05, 6, "tx_req bits for 0x85");
        chk(8'(tx_cycles), 8'h01, 6, "tx_req strobe cycles for 0x85");
        tx_clear = 1; waitc(2); tx_clear = 0;
        sel(); send(8'h82); desel();
        chk({5'd0, tx_seen}, 8'h02, 6, "tx_req bits for 0x82");
        chk(8'(tx_cycles), 8'h01, 6, "tx_req strobe cycles for 0x82");

        // R10 flags and interrupt gating
        wr1(8'h61, 8'hB1); wr1(8'h66, 8'hB6); wr1(8'h71, 8'hC1); wr1(8'h76, 8'hC6);
        host_pulse(2'b11);
        chk({7'd0, int_n}, 8'h01, 10, "int_n with enable 0");
        rd1(8'h2C, 8'h03, 10);
        wr1(8'h2B, 8'h01);
        waitc(2);
        chk({7'd0, int_n}, 8'h00, 10, "int_n with enable 1");

        // R7 receive-buffer reads and flag clearing
        sel(); send(8'h90); expect_byte(8'hB1, 7); desel();
        rd1(8'h2C, 8'h02, 7);
        chk({7'd0, int_n}, 8'h01, 10, "int_n after flag 0 cleared");
        sel(); send(8'h96); expect_byte(8'hC6, 7); desel();
        rd1(8'h2C, 8'h00, 7);
        sel(); send(8'h92); expect_byte(8'hB6, 7); expect_byte(8'h00, 7); desel();
        sel(); send(8'h94); expect_byte(8'hC1, 7); desel();
        host_pulse(2'b10);
        wr1(8'h2B, 8'h02);
        waitc(2);
        chk({7'd0, int_n}, 8'h00, 10, "int_n flag 1 enabled");

        // R1 soft reset command
        wr1(8'h0F, 8'h00);
        rd1(8'h0F, 8'h00, 1);
        sel(); send(8'hC0); desel();
        chk({7'd0, int_n}, 8'h01, 1, "int_n after reset command");
        rd1(8'h0F, 8'h80, 1);
        rd1(8'h20, 8'h00, 1);
        rd1(8'h2C, 8'h00, 1);

        waitc(10);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule